// File: doc/BRIEF.md
# Sleep and Wake Controller

This block decides when a small processor core goes to sleep and when it comes back. The core raises a one-cycle strobe when it decodes its sleep instruction. If the sleep-enable control bit is set at that moment, the block latches the 3-bit mode field and gates the clock domains that the chosen mode shuts down. It then holds the core halted until it sees an enabled interrupt request or a reset request.

Waking on an interrupt has three phases. Waking from the deepest mode first waits out a parameterised oscillator start-up count. All modes then add a fixed four-cycle hold. After that the core is released with a one-cycle `wakeValid` pulse, and `wakeCause` tells it whether to service the interrupt and then continue after the sleep instruction, or to restart from the reset vector. A reset request that arrives at any point while the core is halted overrides interrupt resumption. The block drives no clear or reset toward registers or memory, so their contents survive sleep.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: When `sleepStrobe` is 1, `sleepEn` is 1 and no interrupt is pending, `coreHalt` rises on the next cycle. A strobe with `sleepEn` at 0 leaves `coreHalt` at 0 and all clocks enabled.
- R2: When an interrupt request is pending in the same cycle as the strobe, sleep is not entered and `coreHalt` stays 0.
- R3: The mode field selects which clocks are gated while asleep. Code 000 (light) gates only `cpuClkEn`. Code 001 (quiet) gates `cpuClkEn` and `ioClkEn` and keeps `adcClkEn` running. Code 010 (deep) gates all three. Codes 011 to 111 behave as code 000.
- R4: The mode is captured at the strobe. Changing `sleepMode` while asleep does not change the clock gates or the wake timing.
- R5: From light or quiet mode, an interrupt sampled at clock edge E keeps `coreHalt` at 1 for exactly 4 more cycles after E. The core is then released, with `wakeValid` pulsing for one cycle and `wakeCause` = 0 (interrupt).
- R6: From deep mode, an interrupt sampled at edge E keeps `coreHalt` at 1 for STARTUP_CYCLES + 4 cycles after E, then releases the core as in R5.
- R7: `wakeReset` sampled while `coreHalt` is 1 (asleep, in start-up or in the hold) releases the core on the next cycle with `wakeValid` = 1 and `wakeCause` = 1 (reset vector). This takes precedence over any interrupt in the same cycle.
- R8: Interrupt activity during start-up or the hold neither shortens nor lengthens the wake sequence.
- R9: While `coreHalt` is 0, all three clock enables are 1. `wakeValid` is only ever 1 in a cycle in which `coreHalt` is 0.
- R10: `wakeReset` while the core is running has no effect: `coreHalt` and `wakeValid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the always-on wake logic |
| rstN | input | 1 | Asynchronous active-low reset of this block |
| sleepEn | input | 1 | Sleep-enable control bit |
| sleepMode | input | 3 | Sleep mode select (see R3) |
| sleepStrobe | input | 1 | One-cycle pulse from sleep-instruction decode |
| irqPending | input | IRQ_W | Enabled, pending interrupt requests |
| wakeReset | input | 1 | Reset request toward the core |
| cpuClkEn | output | 1 | CPU clock enable |
| ioClkEn | output | 1 | I/O clock enable |
| adcClkEn | output | 1 | Converter clock enable |
| coreHalt | output | 1 | Holds the core stopped |
| wakeValid | output | 1 | One-cycle pulse when the core is released |
| wakeCause | output | 1 | 0 = resume via interrupt, 1 = restart from reset vector |

## Verification
The bench aims at the exact length of the halt for each mode. A design that applied the start-up count to light or quiet mode, or dropped the four-cycle hold, would report wrong halt lengths to the scoreboard. It drives interrupts together with the sleep strobe, and a strobe with the enable cleared; a design that checked only one of the two conditions would halt when it should not. It changes the mode inputs mid-sleep and raises reset during start-up while an interrupt is also active. A design that decoded the live mode, or let the interrupt path win, would show changed gates or a resume with the wrong cause.

// File: rtl/sleep_wake_pkg.sv
package sleep_wake_pkg;

  typedef enum logic [1:0] {
    KIND_LIGHT,
    KIND_QUIET,
    KIND_DEEP
  } sleepKind_t;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_HOLD
  } swState_t;

  typedef struct packed {
    logic latchMode;
    logic loadStart;
    logic loadHold;
    logic tick;
    logic flagIrq;
    logic flagReset;
  } swStrobe_t;

  function automatic sleepKind_t decodeKind(input logic [2:0] code);
    case (code)
      3'b001:  decodeKind = KIND_QUIET;
      3'b010:  decodeKind = KIND_DEEP;
      default: decodeKind = KIND_LIGHT;
    endcase
  endfunction

endpackage

// File: rtl/swc_datapath.sv
module swc_datapath
  import sleep_wake_pkg::*;
#(
  parameter int STARTUP_CYCLES = 16,
  parameter int HOLD_CYCLES    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] sleepMode,
  input  swStrobe_t  strb,
  input  swState_t   state,
  output logic       cntZero,
  output logic       isDeep,
  output logic       cpuClkEn,
  output logic       ioClkEn,
  output logic       adcClkEn,
  output logic       wakeValid,
  output logic       wakeCause
);

  localparam int MAX_COUNT = (STARTUP_CYCLES > HOLD_CYCLES) ? STARTUP_CYCLES : HOLD_CYCLES;
  localparam int CNT_W     = (MAX_COUNT > 1) ? $clog2(MAX_COUNT + 1) : 1;
  localparam logic [CNT_W-1:0] START_LOAD = (STARTUP_CYCLES > 0) ? CNT_W'(STARTUP_CYCLES - 1) : '0;
  localparam logic [CNT_W-1:0] HOLD_LOAD  = (HOLD_CYCLES > 0) ? CNT_W'(HOLD_CYCLES - 1) : '0;

  sleepKind_t       kindReg;
  logic [CNT_W-1:0] cnt;
  logic             sleeping;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindReg <= KIND_LIGHT;
    end else if (strb.latchMode) begin
      kindReg <= decodeKind(sleepMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadStart) begin
      cnt <= START_LOAD;
    end else if (strb.loadHold) begin
      cnt <= HOLD_LOAD;
    end else if (strb.tick && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeValid <= 1'b0;
      wakeCause <= 1'b0;
    end else begin
      wakeValid <= strb.flagIrq | strb.flagReset;
      if (strb.flagReset) begin
        wakeCause <= 1'b1;
      end else if (strb.flagIrq) begin
        wakeCause <= 1'b0;
      end
    end
  end

  assign cntZero  = (cnt == '0);
  assign isDeep   = (kindReg == KIND_DEEP);
  assign sleeping = (state == ST_SLEEP) || (state == ST_START);

  always_comb begin
    cpuClkEn = 1'b1;
    ioClkEn  = 1'b1;
    adcClkEn = 1'b1;
    if (sleeping) begin
      cpuClkEn = 1'b0;
      if (kindReg != KIND_LIGHT) ioClkEn  = 1'b0;
      if (kindReg == KIND_DEEP)  adcClkEn = 1'b0;
    end
  end

endmodule

// File: rtl/swc_ctrl.sv
module swc_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int STARTUP_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sleepEn,
  input  logic      sleepStrobe,
  input  logic      anyIrq,
  input  logic      wakeReset,
  input  logic      cntZero,
  input  logic      isDeep,
  output swStrobe_t strb,
  output swState_t  state,
  output logic      coreHalt
);

  localparam bit HAS_STARTUP = (STARTUP_CYCLES > 0);

  swState_t nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_RUN: begin
        if (sleepStrobe && sleepEn && !anyIrq) begin
          nextState      = ST_SLEEP;
          strb.latchMode = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wakeReset) begin
          nextState      = ST_RUN;
          strb.flagReset = 1'b1;
        end else if (anyIrq) begin
          if (isDeep && HAS_STARTUP) begin
            nextState      = ST_START;
            strb.loadStart = 1'b1;
          end else begin
            nextState     = ST_HOLD;
            strb.loadHold = 1'b1;
          end
        end
      end
      ST_START: begin
        if (wakeReset) begin
          nextState      = ST_RUN;
          strb.flagReset = 1'b1;
        end else if (cntZero) begin
          nextState     = ST_HOLD;
          strb.loadHold = 1'b1;
        end else begin
          strb.tick = 1'b1;
        end
      end
      default: begin
        if (wakeReset) begin
          nextState      = ST_RUN;
          strb.flagReset = 1'b1;
        end else if (cntZero) begin
          nextState    = ST_RUN;
          strb.flagIrq = 1'b1;
        end else begin
          strb.tick = 1'b1;
        end
      end
    endcase
  end

  assign coreHalt = (state != ST_RUN);

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int IRQ_W          = 8,
  parameter int STARTUP_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepEn,
  input  logic [2:0]       sleepMode,
  input  logic             sleepStrobe,
  input  logic [IRQ_W-1:0] irqPending,
  input  logic             wakeReset,
  output logic             cpuClkEn,
  output logic             ioClkEn,
  output logic             adcClkEn,
  output logic             coreHalt,
  output logic             wakeValid,
  output logic             wakeCause
);

  localparam int HOLD_CYCLES = 4;

  swStrobe_t strb;
  swState_t  state;
  logic      cntZero;
  logic      isDeep;

  swc_ctrl #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sleepEn     (sleepEn),
    .sleepStrobe (sleepStrobe),
    .anyIrq      (|irqPending),
    .wakeReset   (wakeReset),
    .cntZero     (cntZero),
    .isDeep      (isDeep),
    .strb        (strb),
    .state       (state),
    .coreHalt    (coreHalt)
  );

  swc_datapath #(
    .STARTUP_CYCLES (STARTUP_CYCLES),
    .HOLD_CYCLES    (HOLD_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sleepMode (sleepMode),
    .strb      (strb),
    .state     (state),
    .cntZero   (cntZero),
    .isDeep    (isDeep),
    .cpuClkEn  (cpuClkEn),
    .ioClkEn   (ioClkEn),
    .adcClkEn  (adcClkEn),
    .wakeValid (wakeValid),
    .wakeCause (wakeCause)
  );

endmodule

// File: rtl/sleep_wake_ctrl_chk.sv
module sleep_wake_ctrl_chk #(
  parameter int IRQ_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sleepEn,
  input logic             sleepStrobe,
  input logic [IRQ_W-1:0] irqPending,
  input logic             wakeReset,
  input logic             cpuClkEn,
  input logic             ioClkEn,
  input logic             adcClkEn,
  input logic             coreHalt,
  input logic             wakeValid,
  input logic             wakeCause
);

  a_r1_no_entry_without_en: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && sleepStrobe && !sleepEn) |=> !coreHalt);

  a_r1_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && sleepStrobe && sleepEn && irqPending == '0) |=> coreHalt);

  a_r2_irq_blocks_entry: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && irqPending != '0) |=> !coreHalt);

  a_r3_gate_nesting: assert property (@(posedge clk) disable iff (!rstN)
    (!adcClkEn |-> !ioClkEn) and (!ioClkEn |-> !cpuClkEn));

  a_r4_gates_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuClkEn && $past(!cpuClkEn)) |-> ($stable(ioClkEn) && $stable(adcClkEn)));

  a_r7_reset_wins: assert property (@(posedge clk) disable iff (!rstN)
    (coreHalt && wakeReset) |=> (!coreHalt && wakeValid && wakeCause));

  a_r9_clocks_on_when_running: assert property (@(posedge clk) disable iff (!rstN)
    !coreHalt |-> (cpuClkEn && ioClkEn && adcClkEn));

  a_r9_release_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wakeValid |-> (!coreHalt && $past(coreHalt)));

  a_r10_reset_in_run: assert property (@(posedge clk) disable iff (!rstN)
    (!coreHalt && wakeReset && !sleepStrobe) |=> (!coreHalt && !wakeValid));

endmodule

bind sleep_wake_ctrl sleep_wake_ctrl_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepEn     (sleepEn),
  .sleepStrobe (sleepStrobe),
  .irqPending  (irqPending),
  .wakeReset   (wakeReset),
  .cpuClkEn    (cpuClkEn),
  .ioClkEn     (ioClkEn),
  .adcClkEn    (adcClkEn),
  .coreHalt    (coreHalt),
  .wakeValid   (wakeValid),
  .wakeCause   (wakeCause)
);

// File: tb/sleep_wake_ctrl_tb.sv
module sleep_wake_ctrl_tb;

  localparam int IRQ_W = 8;
  localparam int START = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sleepEn = 1'b0;
  logic [2:0]       sleepMode = 3'b000;
  logic             sleepStrobe = 1'b0;
  logic [IRQ_W-1:0] irqPending = '0;
  logic             wakeReset = 1'b0;
  logic             cpuClkEn, ioClkEn, adcClkEn, coreHalt, wakeValid, wakeCause;

  int tests = 0;
  int fails = 0;
  int haltCnt = 0;
  int cycles = 0;

  typedef struct {
    int    len;
    bit    cause;
    string req;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  sleep_wake_ctrl #(.IRQ_W(IRQ_W), .STARTUP_CYCLES(START)) u_dut (
    .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .sleepMode(sleepMode),
    .sleepStrobe(sleepStrobe), .irqPending(irqPending), .wakeReset(wakeReset),
    .cpuClkEn(cpuClkEn), .ioClkEn(ioClkEn), .adcClkEn(adcClkEn),
    .coreHalt(coreHalt), .wakeValid(wakeValid), .wakeCause(wakeCause)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: counts halted cycles and scores each release against the queue
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (wakeValid) begin
        if (expQ.size() == 0) begin
          check("R9 unexpected release", 1, 0);
        end else begin
          check({expQ[0].req, " halt length"}, haltCnt, expQ[0].len);
          check({expQ[0].req, " wake cause"}, int'(wakeCause), int'(expQ[0].cause));
          void'(expQ.pop_front());
        end
        haltCnt = 0;
      end else if (coreHalt) begin
        haltCnt++;
      end
    end
  end

  // kind: 0 = irq wake, 1 = reset while asleep, 2 = irq then reset during start-up
  task automatic sleepCycle(input logic [2:0] mode, input int w, input int kind,
                            input int irqHold, input int expLen, input bit expCause,
                            input logic eCpu, input logic eIo, input logic eAdc,
                            input string req);
    @(negedge clk);
    sleepEn = 1'b1; sleepMode = mode; sleepStrobe = 1'b1;
    @(negedge clk);
    sleepStrobe = 1'b0;
    check({req, " R1 halted"}, int'(coreHalt), 1);
    check({req, " R3 gates"}, int'({cpuClkEn, ioClkEn, adcClkEn}), int'({eCpu, eIo, eAdc}));
    sleepMode = ~mode;  // R4: live mode changes must be ignored
    sleepEn = 1'b0;
    repeat (w - 1) @(negedge clk);
    check({req, " R4 gates held"}, int'({cpuClkEn, ioClkEn, adcClkEn}), int'({eCpu, eIo, eAdc}));
    expQ.push_back('{len: expLen, cause: expCause, req: req});
    if (kind == 1) begin
      wakeReset = 1'b1; irqPending = 8'h04;
      @(negedge clk);
      wakeReset = 1'b0; irqPending = '0;
    end else begin
      irqPending = 8'h10;
      repeat (irqHold) @(negedge clk);
      irqPending = '0;
      if (kind == 2) begin
        @(negedge clk);
        wakeReset = 1'b1; irqPending = 8'h01;
        @(negedge clk);
        wakeReset = 1'b0; irqPending = '0;
      end
    end
    while (expQ.size() != 0) @(negedge clk);
    check({req, " R9 clocks after release"}, int'({cpuClkEn, ioClkEn, adcClkEn}), 7);
  endtask

  initial begin : watchdog
    while (cycles < 20000) @(negedge clk);
    check("watchdog", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("reset coreHalt", int'(coreHalt), 0);
    check("reset clocks", int'({cpuClkEn, ioClkEn, adcClkEn}), 7);
    check("reset wakeValid", int'(wakeValid), 0);
    check("reset wakeCause", int'(wakeCause), 0);

    // R1: strobe without enable
    sleepEn = 1'b0; sleepStrobe = 1'b1;
    @(negedge clk);
    sleepStrobe = 1'b0;
    check("R1 strobe without enable", int'(coreHalt), 0);
    check("R1 clocks without enable", int'({cpuClkEn, ioClkEn, adcClkEn}), 7);

    // R2: interrupt coincides with strobe
    sleepEn = 1'b1; sleepStrobe = 1'b1; irqPending = 8'h80;
    @(negedge clk);
    sleepStrobe = 1'b0; irqPending = '0; sleepEn = 1'b0;
    check("R2 irq blocks entry", int'(coreHalt), 0);

    // R10: reset request while running
    wakeReset = 1'b1;
    @(negedge clk);
    wakeReset = 1'b0;
    check("R10 reset in run halt", int'(coreHalt), 0);
    check("R10 reset in run pulse", int'(wakeValid), 0);

    // R5: light and quiet wake lengths; reserved code acts as light (R3)
    sleepCycle(3'b000, 3, 0, 1, 3 + 4, 1'b0, 1'b0, 1'b1, 1'b1, "R5 light");
    sleepCycle(3'b001, 5, 0, 1, 5 + 4, 1'b0, 1'b0, 1'b0, 1'b1, "R5 quiet");
    sleepCycle(3'b101, 2, 0, 1, 2 + 4, 1'b0, 1'b0, 1'b1, 1'b1, "R3 reserved");
    // R6: deep wake adds start-up; R8: irq held into start-up changes nothing
    sleepCycle(3'b010, 4, 0, 1, 4 + START + 4, 1'b0, 1'b0, 1'b0, 1'b0, "R6 deep");
    sleepCycle(3'b010, 2, 0, 3, 2 + START + 4, 1'b0, 1'b0, 1'b0, 1'b0, "R8 deep held irq");
    // R7: reset while asleep, and reset during start-up
    sleepCycle(3'b001, 6, 1, 1, 6, 1'b1, 1'b0, 1'b0, 1'b1, "R7 reset asleep");
    sleepCycle(3'b010, 3, 2, 1, 3 + 2, 1'b1, 1'b0, 1'b0, 1'b0, "R7 reset in startup");
    // R5 after a reset wake: cause returns to interrupt
    sleepCycle(3'b000, 2, 0, 1, 2 + 4, 1'b0, 1'b0, 1'b1, 1'b1, "R5 cause restored");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule